// File: doc/BRIEF.md
# Byte Accumulator Arithmetic Unit

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. It holds an accumulator register and a flag register. Each cycle it works out, without a clock, a new accumulator value and new flags from the operation code, the second operand and the present register contents. When the write strobe is high, the rising clock edge commits both results.

There are fourteen operations: binary add and subtract with and without the carry, compare, the three bitwise operations, accumulator increment and decrement, accumulator inversion, two carry-flag operations, and a decimal correction step for packed BCD. Each operation follows its own rule for which flags it rewrites and which it keeps. The decimal correction works after either an addition or a subtraction, and the stored subtract flag tells it which one came before.

Top module: `acc_alu8`

## Requirements
- R1: A synchronous reset loads the accumulator with 0x01 and the flag register with 0xB0 (zero, half-carry and carry set).
- R2: The flag register holds zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3..0 always read 0.
- R3: Registers change only on a rising edge with `wr_en` high. With `wr_en` low they hold their values.
- R4: Opcode 0 (add) and opcode 1 (add with carry-in) store the low byte of A+B(+C). Carry is set when the sum exceeds 0xFF. Half-carry is bit 4 of sum XOR A XOR B. Zero follows the stored byte. Subtract is cleared.
- R5: Opcode 2 (subtract) stores A−B. It sets subtract, sets carry when B > A, and sets half-carry when B's low nibble exceeds A's. Opcode 3 (subtract with borrow) stores A−B−C. It sets subtract, sets carry when the true difference is negative, and takes half-carry from bit 4 of difference XOR A XOR B. Zero follows the stored byte in both cases.
- R6: Opcode 4 (compare) sets the flags exactly as opcode 2 would and leaves the accumulator unchanged.
- R7: Opcode 5 (AND) sets only half-carry and zero. Opcode 6 (OR) and opcode 7 (XOR) set only zero. All other flags are cleared.
- R8: Opcode 8 increments A. Half-carry is set when the result's low nibble is 0x0. Opcode 9 decrements A. Half-carry is set when the result's low nibble is 0xF, and subtract is set. Both keep carry, and zero follows the result.
- R9: Opcode 10 inverts A, sets subtract and half-carry, and keeps zero and carry.
- R10: Opcode 11 sets carry. Opcode 12 inverts carry. Both clear subtract and half-carry and keep zero.
- R11: Opcode 13 (decimal correction) builds a correction value. It adds 0x06 when half-carry is set or A's low nibble is above 9. It adds 0x60 when carry is set or A's high nibble is above 9. The correction is added to A when subtract is clear and taken from A when it is set.
- R12: After opcode 13, subtract keeps its old value, half-carry is cleared, carry is set exactly when the correction holds 0x60, and zero follows the new accumulator.
- R13: Opcodes 14 and 15 change neither register, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Commit strobe for accumulator and flags |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator register |
| flags_o | output | 8 | Flag register |

## Verification
The bench targets the half-carry rules, because every operation family defines half-carry its own way. A design that shares one nibble rule across add, subtract, subtract with borrow and decrement gives the wrong bit 5 in one or more vector rows. Carry and zero are exercised at wrap points: 0xFF plus carry-in, zero minus borrow, increment from 0xFF and decrement from 0x00. A design that loses the ninth bit or tests zero before masking fails there. For decimal correction the bench runs both directions and both correction nibbles, so a missing subtract path or a high-nibble test set at the wrong threshold shows up. The reserved codes and a cycle with the strobe low check that nothing moves, and compare checks that the accumulator is not overwritten.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

    localparam int DW = 8;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_CPL = 4'd10,
        OP_SCF = 4'd11,
        OP_CCF = 4'd12,
        OP_DAA = 4'd13,
        OP_RS0 = 4'd14,
        OP_RS1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        flag_t         fl;
    } alu_state_t;

endpackage

// File: rtl/acc_alu8_arith.sv
module acc_alu8_arith
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flag_t         f_in,
    output logic [DW-1:0] res,
    output flag_t         f_out
);
    localparam int EW = DW + 2;

    logic [EW-1:0] a_e, b_e, c_e, s_e, x_e;

    always_comb begin
        a_e   = {2'b00, a};
        b_e   = {2'b00, b};
        c_e   = {{(EW-1){1'b0}}, f_in.c};
        s_e   = '0;
        f_out = f_in;
        case (op)
            OP_ADD:         s_e = a_e + b_e;
            OP_ADC:         s_e = a_e + b_e + c_e;
            OP_SUB, OP_CMP: s_e = a_e - b_e;
            OP_SBC:         s_e = a_e - b_e - c_e;
            OP_INC:         s_e = a_e + {{(EW-1){1'b0}}, 1'b1};
            OP_DEC:         s_e = a_e - {{(EW-1){1'b0}}, 1'b1};
            default:        s_e = a_e;
        endcase
        x_e = s_e ^ a_e ^ b_e;
        res = s_e[DW-1:0];
        case (op)
            OP_ADD, OP_ADC: begin
                f_out.n = 1'b0;
                f_out.h = x_e[4];
                f_out.c = s_e[DW];
            end
            OP_SUB, OP_CMP: begin
                f_out.n = 1'b1;
                f_out.h = (a[3:0] < b[3:0]);
                f_out.c = s_e[EW-1];
            end
            OP_SBC: begin
                f_out.n = 1'b1;
                f_out.h = x_e[4];
                f_out.c = s_e[EW-1];
            end
            OP_INC: begin
                f_out.n = 1'b0;
                f_out.h = (s_e[3:0] == 4'h0);
            end
            OP_DEC: begin
                f_out.n = 1'b1;
                f_out.h = (s_e[3:0] == 4'hF);
            end
            default: ;
        endcase
        f_out.z = (res == '0);
    end
endmodule

// File: rtl/acc_alu8_logic.sv
module acc_alu8_logic
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flag_t         f_in,
    output logic [DW-1:0] res,
    output flag_t         f_out
);
    always_comb begin
        res   = a;
        f_out = f_in;
        case (op)
            OP_AND: begin
                res   = a & b;
                f_out = '{z: (res == '0), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_OR: begin
                res   = a | b;
                f_out = '{z: (res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_XOR: begin
                res   = a ^ b;
                f_out = '{z: (res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_CPL: begin
                res     = ~a;
                f_out.n = 1'b1;
                f_out.h = 1'b1;
            end
            OP_SCF: begin
                f_out.n = 1'b0;
                f_out.h = 1'b0;
                f_out.c = 1'b1;
            end
            OP_CCF: begin
                f_out.n = 1'b0;
                f_out.h = 1'b0;
                f_out.c = ~f_in.c;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu8_bcd.sv
module acc_alu8_bcd
    import acc_alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  flag_t         f_in,
    output logic [DW-1:0] res,
    output flag_t         f_out
);
    logic [DW-1:0] corr;

    always_comb begin
        corr = '0;
        if (f_in.h || (a[3:0] > 4'd9)) corr[3:0] = 4'h6;
        if (f_in.c || (a[7:4] > 4'd9)) corr[7:4] = 4'h6;
        res     = f_in.n ? (a - corr) : (a + corr);
        f_out.n = f_in.n;
        f_out.h = 1'b0;
        f_out.c = (corr[7:4] != 4'h0);
        f_out.z = (res == '0);
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
#(
    parameter logic [7:0] RST_ACC  = 8'h01,
    parameter logic [3:0] RST_FLAG = 4'hB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] op_i,
    input  logic [7:0] opnd_i,
    output logic [7:0] acc_o,
    output logic [7:0] flags_o
);
    alu_state_t    st_q, st_d;
    alu_op_e       op;
    logic [DW-1:0] ar_res, lg_res, bc_res;
    flag_t         ar_fl, lg_fl, bc_fl;

    assign op = alu_op_e'(op_i);

    acc_alu8_arith u_arith (
        .op(op), .a(st_q.acc), .b(opnd_i), .f_in(st_q.fl),
        .res(ar_res), .f_out(ar_fl)
    );
    acc_alu8_logic u_logic (
        .op(op), .a(st_q.acc), .b(opnd_i), .f_in(st_q.fl),
        .res(lg_res), .f_out(lg_fl)
    );
    acc_alu8_bcd u_bcd (
        .a(st_q.acc), .f_in(st_q.fl), .res(bc_res), .f_out(bc_fl)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC:
                    st_d = '{acc: ar_res, fl: ar_fl};
                OP_CMP:
                    st_d.fl = ar_fl;
                OP_AND, OP_OR, OP_XOR, OP_CPL, OP_SCF, OP_CCF:
                    st_d = '{acc: lg_res, fl: lg_fl};
                OP_DAA:
                    st_d = '{acc: bc_res, fl: bc_fl};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{acc: RST_ACC, fl: flag_t'(RST_FLAG)};
        else     st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign flags_o = {st_q.fl, 4'h0};

    a_r2_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        flags_o[3:0] == 4'h0);
    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(acc_o) && $stable(flags_o));
    a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i == 4'd4) |=> acc_o == $past(acc_o));
    a_r8_step_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (op_i == 4'd8 || op_i == 4'd9)) |=> flags_o[4] == $past(flags_o[4]));
    a_r9_cpl_inverts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i == 4'd10) |=> acc_o == ~$past(acc_o));
    a_r10_scf_sets_carry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i == 4'd11) |=> flags_o[6:4] == 3'b001);
    a_r12_daa_keeps_n: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i == 4'd13) |=> flags_o[6] == $past(flags_o[6]) && !flags_o[5]);
    a_r13_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i[3:1] == 3'b111) |=> $stable(acc_o) && $stable(flags_o));
endmodule

// File: tb/acc_alu8_test.sv
module acc_alu8_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] op_i;
    logic [7:0] opnd_i;
    logic [7:0] acc_o, flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    acc_alu8 uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op_i(op_i),
        .opnd_i(opnd_i), .acc_o(acc_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // a[42:35] c[34] nh[33] op[32:29] b[28:21] exp_a[20:13] exp_f[12:5] req[4:0]
    localparam logic [42:0] VEC [NV] = '{
        {8'h3A,1'b0,1'b0,4'd0, 8'hC6,8'h00,8'hB0,5'd4},   // R4 add wraps to zero
        {8'h0F,1'b0,1'b0,4'd0, 8'h01,8'h10,8'h20,5'd4},   // R4 nibble carry
        {8'hE1,1'b1,1'b0,4'd1, 8'h0F,8'hF1,8'h20,5'd4},   // R4 add with carry-in
        {8'hFF,1'b1,1'b0,4'd1, 8'h00,8'h00,8'hB0,5'd4},   // R4 carry-in overflow
        {8'h3E,1'b0,1'b0,4'd2, 8'h0F,8'h2F,8'h60,5'd5},   // R5 nibble borrow
        {8'h3E,1'b0,1'b0,4'd2, 8'h3E,8'h00,8'hC0,5'd5},   // R5 equal
        {8'h3E,1'b0,1'b0,4'd2, 8'h40,8'hFE,8'h50,5'd5},   // R5 full borrow
        {8'h3B,1'b1,1'b0,4'd3, 8'h2A,8'h10,8'h40,5'd5},   // R5 borrow-in
        {8'h00,1'b1,1'b0,4'd3, 8'h00,8'hFF,8'h70,5'd5},   // R5 zero minus borrow
        {8'h3C,1'b0,1'b0,4'd4, 8'h2F,8'h3C,8'h60,5'd6},   // R6 compare
        {8'h3C,1'b0,1'b0,4'd4, 8'h3C,8'h3C,8'hC0,5'd6},   // R6 compare equal
        {8'h5A,1'b1,1'b0,4'd5, 8'h3F,8'h1A,8'h20,5'd7},   // R7 and
        {8'h5A,1'b0,1'b0,4'd5, 8'hA5,8'h00,8'hA0,5'd7},   // R7 and zero
        {8'h00,1'b1,1'b0,4'd6, 8'h00,8'h00,8'h80,5'd7},   // R7 or zero
        {8'hFF,1'b1,1'b0,4'd7, 8'h0F,8'hF0,8'h00,5'd7},   // R7 xor
        {8'hFF,1'b1,1'b0,4'd8, 8'h00,8'h00,8'hB0,5'd8},   // R8 inc wrap
        {8'h50,1'b0,1'b0,4'd8, 8'h00,8'h51,8'h00,5'd8},   // R8 inc plain
        {8'h01,1'b0,1'b0,4'd9, 8'h00,8'h00,8'hC0,5'd8},   // R8 dec to zero
        {8'h00,1'b1,1'b0,4'd9, 8'h00,8'hFF,8'h70,5'd8},   // R8 dec wrap
        {8'h20,1'b0,1'b0,4'd9, 8'h00,8'h1F,8'h60,5'd8},   // R8 dec nibble
        {8'h35,1'b1,1'b0,4'd10,8'h00,8'hCA,8'h70,5'd9},   // R9 invert
        {8'h00,1'b0,1'b1,4'd11,8'h00,8'h00,8'h90,5'd10},  // R10 set carry
        {8'h12,1'b1,1'b1,4'd12,8'h00,8'h12,8'h00,5'd10},  // R10 flip carry off
        {8'h12,1'b0,1'b0,4'd12,8'h00,8'h12,8'h10,5'd10},  // R10 flip carry on
        {8'h9A,1'b0,1'b0,4'd13,8'h00,8'hA0,8'h00,5'd11},  // R11 low fix
        {8'hA0,1'b0,1'b0,4'd13,8'h00,8'h00,8'h90,5'd12},  // R12 high fix, zero
        {8'h15,1'b1,1'b0,4'd13,8'h00,8'h75,8'h10,5'd12},  // R12 carry forces 0x60
        {8'h45,1'b0,1'b1,4'd13,8'h00,8'h3F,8'h40,5'd11},  // R11 subtract path
        {8'hF0,1'b1,1'b1,4'd13,8'h00,8'h8A,8'h50,5'd11},  // R11 both nibbles down
        {8'h77,1'b1,1'b1,4'd14,8'hFF,8'h77,8'h70,5'd13},  // R13 reserved 14
        {8'h00,1'b0,1'b0,4'd15,8'h12,8'h00,8'h80,5'd13}   // R13 reserved 15
    };

    task automatic step(input logic [3:0] op, input logic [7:0] b);
        @(negedge clk);
        op_i = op; opnd_i = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic preset(input logic [7:0] a, input logic c, input logic nh);
        step(4'd5, 8'h00);
        step(4'd6, a);
        step(4'd11, 8'h00);
        if (!c) step(4'd12, 8'h00);
        if (nh) begin
            step(4'd10, 8'h00);
            step(4'd10, 8'h00);
        end
    endtask

    task automatic check(input int req, input logic [7:0] ea, input logic [7:0] ef);
        n_checks++;
        if (acc_o !== ea || flags_o !== ef) begin
            n_fail++;
            $display("FAIL R%0d: acc=%02h flags=%02h expected acc=%02h flags=%02h",
                     req, acc_o, flags_o, ea, ef);
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; op_i = 4'd0; opnd_i = 8'h00;
        repeat (2) @(negedge clk);
        check(1, 8'h01, 8'hB0);   // R1 reset values
        rst = 1'b0;
        // R3: strobe low, operand applied, nothing moves
        op_i = 4'd0; opnd_i = 8'h55;
        @(negedge clk);
        check(3, 8'h01, 8'hB0);
        for (int i = 0; i < NV; i++) begin
            preset(VEC[i][42:35], VEC[i][34], VEC[i][33]);
            step(VEC[i][32:29], VEC[i][28:21]);
            check(int'(VEC[i][4:0]), VEC[i][20:13], VEC[i][12:5]);
        end
        // R2: flags low nibble zero after a run of operations
        n_checks++;
        if (flags_o[3:0] !== 4'h0) begin
            n_fail++;
            $display("FAIL R2: low flag bits=%01h expected 0", flags_o[3:0]);
        end
        // R6: compare then add proves A was kept across compare
        preset(8'h10, 1'b0, 1'b0);
        step(4'd4, 8'h80);
        step(4'd0, 8'h01);
        check(6, 8'h11, 8'h00);
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(1, 8'h01, 8'hB0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule